// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block sits next to the fetch stage of a small in-order processor and removes the branch overhead from counted loops. It holds two loop contexts. Each context has a first-instruction address, a last-instruction address and a remaining-iteration count. Context 0 is meant for the inner loop and context 1 for the outer loop, so two loops can be nested.

The decode stage programs a context in one of two ways. It can write the three values one at a time, with any addresses it likes. It can also issue a single fast setup, which derives both addresses from the PC of the setup instruction and loads the count in the same cycle. Whether the count came from a register or an immediate is resolved before the command arrives.

Once a context is armed, the block compares every valid fetch PC against the last address of each context. When a loop must go round again, the block raises a redirect and gives the loop's first address as the next PC. No compare or branch instruction is needed for any iteration.

Top module: `hwloop_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both iteration counts are zero. As a result `loop_active` is all zeros and `redirect` stays low for any fetch PC.
- R2: A command with `cmd_op` = 0 writes `cmd_data` as the first address of the set chosen by `cmd_set`. `cmd_op` = 1 writes `cmd_data` as its last address. `cmd_op` = 2 writes the low count bits of `cmd_data` as its count. Bit i of `loop_active` is 1 exactly when the count of set i is nonzero.
- R3: A command with `cmd_op` = 3 (fast setup) loads first = `cmd_pc` + 4, last = `cmd_pc` + 4 + `cmd_offset` and count = low bits of `cmd_data`, all in one cycle.
- R4: When `fetch_valid` is high, the fetch PC equals the last address of an active set and that set's count is above 1, then `redirect` is high in the same cycle, `redirect_pc` equals that set's first address, and the count drops by one at the next edge.
- R5: On such a match with a count of exactly 1, `redirect` stays low so fetch falls through to last + 4, and the count becomes 0, which deactivates the set.
- R6: With `fetch_valid` low, or with no active set whose last address equals the fetch PC, `redirect` is low and no count changes.
- R7: Set 0 is served first. Set 1 is only considered when set 0 does not match or is on its final iteration. A shared last address therefore retires the inner loop before it repeats the outer one.
- R8: A command aimed at a set in the same cycle as that set's end match wins. The written value is kept, and that set neither redirects nor decrements in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A setup command is present this cycle |
| cmd_op | input | 2 | 0 first address, 1 last address, 2 count, 3 fast setup |
| cmd_set | input | SET_W (1) | Target context, 0 = inner |
| cmd_pc | input | ADDR_W (32) | PC of the setup instruction (fast setup) |
| cmd_data | input | ADDR_W (32) | Address or count value |
| cmd_offset | input | ADDR_W (32) | Distance from first to last address (fast setup) |
| fetch_valid | input | 1 | `fetch_pc` holds a real fetch this cycle |
| fetch_pc | input | ADDR_W (32) | Current fetch address |
| redirect | output | 1 | Next PC must be `redirect_pc` |
| redirect_pc | output | ADDR_W (32) | Loop first address to fetch next |
| loop_active | output | NUM_SETS (2) | Per-set nonzero-count flag |

## Verification
The bench targets four hazards:
- A last address shared by both contexts. A design with the priority reversed would repeat the outer body before the inner loop has finished.
- The final iteration. An off-by-one design would branch back once too often, or would leave the set armed with a count that wraps.
- A setup command that lands on the very cycle of an end match. A design that let the decrement win would lose the freshly written count, or would redirect from stale state.
- End matches with `fetch_valid` low. These must neither redirect nor consume an iteration.

A long random mix of commands and fetch addresses, drawn from a small address window, hits all of these far more often than real code would.

// File: rtl/hwloop_pkg.sv
// Shared definitions for the loop sequencer: command encodings.
package hwloop_pkg;

    // Setup command codes carried on cmd_op.
    typedef enum logic [1:0] {
        OP_FIRST = 2'd0,
        OP_LAST  = 2'd1,
        OP_COUNT = 2'd2,
        OP_FAST  = 2'd3
    } hwl_op_e;

endpackage

// File: rtl/hwloop_set.sv
// One loop context: first address, last address, remaining count.
// What it does: takes setup writes, and decrements the count when the
// arbiter grants an iteration.
// Assumes: the arbiter never raises dec_en for a set that is being written
// in the same cycle; a write still wins if it does.
module hwloop_set
    import hwloop_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  hwl_op_e           wr_op,
    input  logic [ADDR_W-1:0] wr_pc,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] wr_offset,
    input  logic              dec_en,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] last_addr,
    output logic [CNT_W-1:0]  count
);

    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

    logic [ADDR_W-1:0] fast_first;

    // Fast setup: the body begins right after the setup instruction.
    always_comb fast_first = wr_pc + INSN_BYTES;

    // Context registers: a setup write has priority over a decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_addr <= '0;
            last_addr  <= '0;
            count      <= '0;
        end else if (wr_en) begin
            case (wr_op)
                OP_FIRST: first_addr <= wr_data;
                OP_LAST:  last_addr  <= wr_data;
                OP_COUNT: count      <= wr_data[CNT_W-1:0];
                OP_FAST: begin
                    first_addr <= fast_first;
                    last_addr  <= fast_first + wr_offset;
                    count      <= wr_data[CNT_W-1:0];
                end
                default: ;
            endcase
        end else if (dec_en) begin
            count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/hwloop_arb.sv
// Loop-end arbiter: compares the fetch PC with every context's last
// address and chooses which context redirects and which ones decrement.
// What it does: lower-numbered sets are served first; a set on its final
// iteration retires without redirecting and hands the decision on.
// Assumes: the blocked bits mark sets that a setup write targets this cycle.
module hwloop_arb #(
    parameter int NUM_SETS = 2,
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16
) (
    input  logic                             fetch_valid,
    input  logic [ADDR_W-1:0]                fetch_pc,
    input  logic [NUM_SETS-1:0][ADDR_W-1:0]  first_addr,
    input  logic [NUM_SETS-1:0][ADDR_W-1:0]  last_addr,
    input  logic [NUM_SETS-1:0][CNT_W-1:0]   count,
    input  logic [NUM_SETS-1:0]              blocked,
    output logic                             redirect,
    output logic [ADDR_W-1:0]                redirect_pc,
    output logic [NUM_SETS-1:0]              dec_en
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [NUM_SETS-1:0] hit;
    logic [NUM_SETS-1:0] again;
    logic                claimed;

    // Per-set end match and "more iterations to go" flags.
    for (genvar g = 0; g < NUM_SETS; g++) begin : g_match
        assign hit[g]   = fetch_valid && !blocked[g] && (count[g] != '0)
                          && (fetch_pc == last_addr[g]);
        assign again[g] = count[g] > ONE;
    end

    // Priority walk from set 0 upward; the first repeating hit claims the PC.
    always_comb begin
        claimed     = 1'b0;
        redirect    = 1'b0;
        redirect_pc = '0;
        dec_en      = '0;
        for (int i = 0; i < NUM_SETS; i++) begin
            if (!claimed && hit[i]) begin
                dec_en[i] = 1'b1;
                if (again[i]) begin
                    claimed     = 1'b1;
                    redirect    = 1'b1;
                    redirect_pc = first_addr[i];
                end
            end
        end
    end

endmodule

// File: rtl/hwloop_ctrl.sv
// Zero-overhead loop sequencer top.
// What it does: holds NUM_SETS loop contexts (set 0 innermost), decodes the
// setup commands, and redirects fetch to a loop's first address whenever
// the fetch PC reaches its last address with iterations left.
// Assumes: redirect is consumed combinationally by the next-PC mux in the
// same cycle; NUM_SETS is at least 2.
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [SET_W-1:0]    cmd_set,
    input  logic [ADDR_W-1:0]   cmd_pc,
    input  logic [ADDR_W-1:0]   cmd_data,
    input  logic [ADDR_W-1:0]   cmd_offset,
    input  logic                fetch_valid,
    input  logic [ADDR_W-1:0]   fetch_pc,
    output logic                redirect,
    output logic [ADDR_W-1:0]   redirect_pc,
    output logic [NUM_SETS-1:0] loop_active
);

    logic [NUM_SETS-1:0][ADDR_W-1:0] first_q;
    logic [NUM_SETS-1:0][ADDR_W-1:0] last_q;
    logic [NUM_SETS-1:0][CNT_W-1:0]  count_q;
    logic [NUM_SETS-1:0]             wr_sel;
    logic [NUM_SETS-1:0]             dec_en;
    hwl_op_e                         op_dec;

    // Command code to enum.
    always_comb op_dec = hwl_op_e'(cmd_op);

    // One context per set, plus its write select and activity flag.
    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        assign wr_sel[g]      = cmd_valid && (cmd_set == SET_W'(g));
        assign loop_active[g] = count_q[g] != '0;

        hwloop_set #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W)
        ) u_set (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_sel[g]),
            .wr_op      (op_dec),
            .wr_pc      (cmd_pc),
            .wr_data    (cmd_data),
            .wr_offset  (cmd_offset),
            .dec_en     (dec_en[g]),
            .first_addr (first_q[g]),
            .last_addr  (last_q[g]),
            .count      (count_q[g])
        );
    end

    hwloop_arb #(
        .NUM_SETS (NUM_SETS),
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W)
    ) u_arb (
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .first_addr  (first_q),
        .last_addr   (last_q),
        .count       (count_q),
        .blocked     (wr_sel),
        .redirect    (redirect),
        .redirect_pc (redirect_pc),
        .dec_en      (dec_en)
    );

endmodule

// File: rtl/hwloop_chk.sv
// Checker for the loop sequencer, bound to every hwloop_ctrl instance.
// What it does: watches ports only and flags illegal redirect or activity
// behaviour.
// Assumes: the same parameters as the bound instance.
module hwloop_chk #(
    parameter int NUM_SETS = 2,
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16,
    parameter int SET_W    = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic [1:0]          cmd_op,
    input logic [SET_W-1:0]    cmd_set,
    input logic [ADDR_W-1:0]   cmd_data,
    input logic                fetch_valid,
    input logic                redirect,
    input logic [NUM_SETS-1:0] loop_active
);

    // R6
    idle_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> !redirect);

    // R6
    redirect_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (loop_active != '0));

    // R6
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && !cmd_valid) |=> $stable(loop_active));

    // R2
    count_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2) |=>
        (loop_active[$past(cmd_set)] == ($past(cmd_data[CNT_W-1:0]) != '0)));

    // R3
    fast_setup_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd3) |=>
        (loop_active[$past(cmd_set)] == ($past(cmd_data[CNT_W-1:0]) != '0)));

endmodule

bind hwloop_ctrl hwloop_chk #(
    .NUM_SETS (NUM_SETS),
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .SET_W    (SET_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_set     (cmd_set),
    .cmd_data    (cmd_data),
    .fetch_valid (fetch_valid),
    .redirect    (redirect),
    .loop_active (loop_active)
);

// File: tb/tb_hwloop_ctrl.sv
// Self-checking bench: directed loop scenarios plus seeded random traffic,
// checked against a reference model of the requirements.
module tb_hwloop_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [0:0]  cmd_set = '0;
    logic [31:0] cmd_pc = '0;
    logic [31:0] cmd_data = '0;
    logic [31:0] cmd_offset = '0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        redirect;
    logic [31:0] redirect_pc;
    logic [1:0]  loop_active;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] m_first [2];
    logic [31:0] m_last  [2];
    logic [15:0] m_cnt   [2];

    hwloop_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_set     (cmd_set),
        .cmd_pc      (cmd_pc),
        .cmd_data    (cmd_data),
        .cmd_offset  (cmd_offset),
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .redirect    (redirect),
        .redirect_pc (redirect_pc),
        .loop_active (loop_active)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference decision per the priority and blocking rules.
    function automatic void model_eval(input logic fv, input logic [31:0] fpc,
                                       input logic cv, input logic cs,
                                       output logic r, output logic [31:0] rpc,
                                       output logic [1:0] dec);
        r = 1'b0; rpc = '0; dec = '0;
        for (int i = 0; i < 2; i++) begin
            if (!r && fv && !(cv && cs == 1'(i)) && m_cnt[i] != 0 && fpc == m_last[i]) begin
                dec[i] = 1'b1;
                if (m_cnt[i] > 1) begin
                    r = 1'b1;
                    rpc = m_first[i];
                end
            end
        end
    endfunction

    task automatic step(input logic cv, input logic [1:0] op, input logic cs,
                        input logic [31:0] cpc, input logic [31:0] cdat,
                        input logic [31:0] coff, input logic fv,
                        input logic [31:0] fpc, input string tag,
                        output logic [31:0] nxt);
        logic r;
        logic [31:0] rpc;
        logic [1:0] dec;
        @(negedge clk);
        cmd_valid = cv; cmd_op = op; cmd_set = cs; cmd_pc = cpc;
        cmd_data = cdat; cmd_offset = coff; fetch_valid = fv; fetch_pc = fpc;
        #5;
        model_eval(fv, fpc, cv, cs, r, rpc, dec);
        chk(tag, "loop_active", {30'd0, loop_active},
            {30'd0, m_cnt[1] != 0, m_cnt[0] != 0});
        chk(tag, "redirect", {31'd0, redirect}, {31'd0, r});
        if (r) chk(tag, "redirect_pc", redirect_pc, rpc);
        nxt = r ? rpc : fpc + 32'd4;
        @(posedge clk);
        #1;
        for (int i = 0; i < 2; i++) begin
            if (cv && cs == 1'(i)) begin
                case (op)
                    2'd0: m_first[i] = cdat;
                    2'd1: m_last[i] = cdat;
                    2'd2: m_cnt[i] = cdat[15:0];
                    default: begin
                        m_first[i] = cpc + 32'd4;
                        m_last[i] = cpc + 32'd4 + coff;
                        m_cnt[i] = cdat[15:0];
                    end
                endcase
            end else if (dec[i]) begin
                m_cnt[i] = m_cnt[i] - 16'd1;
            end
        end
    endtask

    task automatic cmd(input logic [1:0] op, input logic cs, input logic [31:0] cpc,
                       input logic [31:0] cdat, input logic [31:0] coff, input string tag);
        logic [31:0] unused;
        step(1'b1, op, cs, cpc, cdat, coff, 1'b0, 32'd0, tag, unused);
    endtask

    task automatic run_fetch(input logic [31:0] pc0, input int n, input string tag);
        logic [31:0] pc;
        pc = pc0;
        for (int k = 0; k < n; k++) step(1'b0, 2'd0, 1'b0, 0, 0, 0, 1'b1, pc, tag, pc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] nxt;
        for (int i = 0; i < 2; i++) begin
            m_first[i] = '0; m_last[i] = '0; m_cnt[i] = '0;
        end
        void'($urandom(32'h0000_5eed));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: idle after reset, even at PC 0 which equals the reset last address.
        run_fetch(32'h0, 2, "R1");

        // R2 + R4 + R5: single loop of three passes through 0x100..0x10C.
        cmd(2'd0, 1'b0, 0, 32'h100, 0, "R2");
        cmd(2'd1, 1'b0, 0, 32'h10C, 0, "R2");
        cmd(2'd2, 1'b0, 0, 32'd3, 0, "R2");
        run_fetch(32'h100, 14, "R4");
        chk("R5", "fell_through", {30'd0, loop_active}, 32'd0);

        // R3 + R7: nested loops built with fast setup.
        cmd(2'd3, 1'b1, 32'h1FC, 32'd2, 32'h10, "R3");
        cmd(2'd3, 1'b0, 32'h200, 32'd2, 32'h4, "R3");
        run_fetch(32'h200, 20, "R7");

        // R7: both sets share a last address; inner retires first.
        cmd(2'd0, 1'b0, 0, 32'h300, 0, "R7");
        cmd(2'd1, 1'b0, 0, 32'h308, 0, "R7");
        cmd(2'd2, 1'b0, 0, 32'd2, 0, "R7");
        cmd(2'd0, 1'b1, 0, 32'h2F0, 0, "R7");
        cmd(2'd1, 1'b1, 0, 32'h308, 0, "R7");
        cmd(2'd2, 1'b1, 0, 32'd2, 0, "R7");
        run_fetch(32'h2F0, 24, "R7");

        // R6: end match with fetch_valid low has no effect.
        cmd(2'd3, 1'b0, 32'h3FC, 32'd5, 32'hC, "R6");
        step(1'b0, 2'd0, 1'b0, 0, 0, 0, 1'b0, 32'h40C, "R6", nxt);
        step(1'b0, 2'd0, 1'b0, 0, 0, 0, 1'b1, 32'h500, "R6", nxt);

        // R8: write to the matching set wins in the same cycle.
        step(1'b1, 2'd2, 1'b0, 0, 32'd7, 0, 1'b1, 32'h40C, "R8", nxt);
        step(1'b1, 2'd2, 1'b0, 0, 32'd0, 0, 1'b1, 32'h40C, "R8", nxt);
        step(1'b0, 2'd0, 1'b0, 0, 0, 0, 1'b1, 32'h40C, "R8", nxt);

        // Random mix in a small window so end matches are frequent.
        for (int k = 0; k < 4000; k++) begin
            logic cv, fv, cs;
            logic [1:0] op;
            logic [31:0] dat, fpc, cpc, off;
            cv  = ($urandom % 6) == 0;
            fv  = ($urandom % 8) != 0;
            cs  = 1'($urandom);
            op  = 2'($urandom);
            cpc = 32'h100 + 4 * ($urandom % 16);
            off = 4 * ($urandom % 6);
            dat = (op == 2'd0 || op == 2'd1) ? 32'h100 + 4 * ($urandom % 17)
                                             : $urandom % 5;
            fpc = 32'h100 + 4 * ($urandom % 17);
            step(cv, op, cs, cpc, dat, off, fv, fpc, "R4", nxt);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule